// File: doc/BRIEF.md
# Control Endpoint Handshake Selector

This block picks the handshake that a USB function returns on its control endpoint for each data transaction: ACK, NAK or STALL. The serial interface engine pulses a token-start strobe and reports whether the endpoint buffer is in NAK state. Firmware asks for a stall with a one-cycle set strobe, and withdraws it with a clear strobe. A SETUP token also withdraws it. The block returns a one-cycle handshake code and a data-phase enable.

The stall request is held in a sticky flag. Each transaction checks it twice. The first check is on the clock edge that accepts the token. The second check is GAP clocks later, on the same edge that checks the buffer's NAK state and fixes the decision. A request that arrives between the two checks is therefore seen by the second check. The transaction ends in STALL, and it can never end in ACK while the buffer is in NAK state. Because the decision is fixed on that edge, the data phase always lasts a known, bounded number of cycles. A request that arrives later stays pending and stalls the next token.

A parameter selects the behaviour for non-control endpoints. In that variant, a stall write that lands while a transaction is in progress is dropped.

Top module: `ep_hs_sel`

## Requirements
- R1: After reset, hs_valid and data_en are low and no stall is pending, so the first transaction with a ready buffer returns ACK (code 2'b00).
- R2: Handshake codes are 2'b00 ACK, 2'b01 NAK and 2'b10 STALL. Take E0 as the edge that samples tok_start while the block is idle. hs_valid is high for exactly one cycle, the cycle that follows edge E0+GAP+DATA_LEN.
- R3: The stall request is checked at edge E0 and again at edge E0+GAP. A stall_set sampled on any edge up to and including E0+GAP gives STALL, whatever the buffer state.
- R4: If no stall applies and buf_nak is high at edge E0+GAP, the code is NAK. ACK is never given when buf_nak is high at that edge.
- R5: data_en is high for exactly DATA_LEN consecutive cycles, following edge E0+GAP, and only when the decision is ACK. A stall_set that arrives during the data phase neither stretches nor cuts it short.
- R6: A stall_set sampled after edge E0+GAP does not change the current handshake, and it gives STALL on the next transaction.
- R7: The stall flag is sticky across transactions. It is cleared only by stall_clr or setup_tok, and a clear wins over a set in the same cycle.
- R8: While auto_mode is high, stall_set is ignored.
- R9: With IS_CTRL=0, stall_set is ignored on edges E0+1 to E0+GAP+DATA_LEN+1, while the transaction is in progress, and is accepted while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_start | input | 1 | Token-start strobe from the serial engine; taken only when idle |
| buf_nak | input | 1 | Endpoint buffer is in NAK state |
| stall_set | input | 1 | Firmware stall request strobe |
| stall_clr | input | 1 | Firmware stall clear strobe |
| setup_tok | input | 1 | SETUP token received; clears the stall flag |
| auto_mode | input | 1 | Automatic-response request in progress; blocks stall_set |
| hs_code | output | 2 | Handshake code (00 ACK, 01 NAK, 10 STALL) |
| hs_valid | output | 1 | hs_code is valid for this cycle |
| data_en | output | 1 | Data phase active |

## Verification
The bench moves the stall write across every clock offset of a transaction, from before the token to the edge that ends it. It does this with a ready buffer and with a NAK buffer, and compares each handshake with the one expected at that offset. A design that dropped a request landing in the gap between the two checks would answer ACK, or NAK, where STALL is due. A design that let the late check override the decision would shorten or stretch the data phase, and the enable-cycle count would expose it. Follow-up transactions show whether a late request was carried forward, whether auto mode and the non-control variant really ignore writes, and whether a clear beats a set in the same cycle.

// File: rtl/ep_hs_sel.sv
module ep_hs_sel #(
  parameter int GAP      = 4,
  parameter int DATA_LEN = 8,
  parameter bit IS_CTRL  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_start,
  input  logic       buf_nak,
  input  logic       stall_set,
  input  logic       stall_clr,
  input  logic       setup_tok,
  input  logic       auto_mode,
  output logic [1:0] hs_code,
  output logic       hs_valid,
  output logic       data_en
);
  localparam int LAST = GAP + DATA_LEN + 1;
  localparam int CW   = $clog2(LAST + 1);
  localparam logic [CW-1:0] C_GAP  = CW'(GAP);
  localparam logic [CW-1:0] C_LAST = CW'(LAST);
  localparam logic [1:0] HS_ACK = 2'b00, HS_NAK = 2'b01, HS_STALL = 2'b10;

  logic          busy, flag, stl_hit;
  logic [CW-1:0] cnt;
  logic [1:0]    dec;
  logic          take;

  generate
    if (IS_CTRL) begin : g_ctrl
      assign take = stall_set & ~auto_mode;
    end else begin : g_other
      assign take = stall_set & ~auto_mode & ~busy;
    end
  endgenerate

  wire clr = stall_clr | setup_tok;
  wire eff = (flag | take) & ~clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= 1'b0;
    else        flag <= eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      stl_hit <= 1'b0;
      dec     <= HS_NAK;
    end else if (!busy) begin
      if (tok_start) begin
        busy    <= 1'b1;
        cnt     <= CW'(1);
        stl_hit <= eff;
      end
    end else begin
      cnt <= cnt + CW'(1);
      if (cnt == C_GAP)
        dec <= (stl_hit | eff) ? HS_STALL : (buf_nak ? HS_NAK : HS_ACK);
      if (cnt == C_LAST) busy <= 1'b0;
    end
  end

  assign hs_valid = busy && cnt == C_LAST;
  assign hs_code  = hs_valid ? dec : HS_ACK;
  assign data_en  = busy && dec == HS_ACK && cnt > C_GAP && cnt < C_LAST;
endmodule

// File: rtl/ep_hs_sel_chk.sv
module ep_hs_sel_chk #(
  parameter int GAP = 4,
  parameter int CW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          buf_nak,
  input logic          stall_clr,
  input logic          setup_tok,
  input logic          auto_mode,
  input logic          hs_valid,
  input logic          data_en,
  input logic          busy,
  input logic          flag,
  input logic [CW-1:0] cnt,
  input logic [1:0]    dec
);
  localparam logic [CW-1:0] C_GAP = CW'(GAP);

  // R4
  no_ack_on_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == C_GAP && buf_nak) |=> dec != 2'b00);

  // R3
  gap_stall_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == C_GAP && flag && !stall_clr && !setup_tok) |=> dec == 2'b10);

  // R2
  hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid);

  // R5
  data_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_en) |-> hs_valid);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !stall_clr && !setup_tok) |=> flag);

  // R7
  setup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok |=> !flag);

  // R8
  auto_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && !flag) |=> !flag);
endmodule

bind ep_hs_sel ep_hs_sel_chk #(.GAP(GAP), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .buf_nak(buf_nak), .stall_clr(stall_clr),
  .setup_tok(setup_tok), .auto_mode(auto_mode), .hs_valid(hs_valid),
  .data_en(data_en), .busy(busy), .flag(flag), .cnt(cnt), .dec(dec)
);

// File: tb/ep_hs_sel_test.sv
module ep_hs_sel_test;
  localparam int GAP = 4, DL = 8, LASTC = GAP + DL + 1;
  localparam logic [1:0] ACK = 2'b00, NAK = 2'b01, STL = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_start = 0, buf_nak = 0, stall_set = 0, stall_clr = 0, setup_tok = 0, auto_mode = 0;
  logic [1:0] hs0, hsb;
  logic v0, vb, de0, deb;
  int vectors = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ep_hs_sel #(.GAP(GAP), .DATA_LEN(DL), .IS_CTRL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .tok_start(tok_start), .buf_nak(buf_nak),
    .stall_set(stall_set), .stall_clr(stall_clr), .setup_tok(setup_tok),
    .auto_mode(auto_mode), .hs_code(hs0), .hs_valid(v0), .data_en(de0));

  ep_hs_sel #(.GAP(GAP), .DATA_LEN(DL), .IS_CTRL(1'b0)) uut_other (
    .clk(clk), .rst_n(rst_n), .tok_start(tok_start), .buf_nak(buf_nak),
    .stall_set(stall_set), .stall_clr(stall_clr), .setup_tok(setup_tok),
    .auto_mode(auto_mode), .hs_code(hsb), .hs_valid(vb), .data_en(deb));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vectors++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // k: loop index at which stall_set is sampled (-1 = one edge before token)
  task automatic txn(input int k, input logic [1:0] e0, input logic [1:0] eb, input string rq);
    logic [1:0] c0 = 2'b11, cb = 2'b11;
    int d0 = 0, db = 0, n0 = 0, nb = 0;
    int ok_at = 1;
    for (int c = -1; c <= LASTC; c++) begin
      tok_start = (c == 0);
      stall_set = (c == k);
      @(posedge clk); @(negedge clk);
      if (de0) d0++;
      if (deb) db++;
      if (v0) begin n0++; c0 = hs0; if (c != GAP + DL) ok_at = 0; end
      if (vb) begin nb++; cb = hsb; end
    end
    tok_start = 0; stall_set = 0;
    chk(c0 == e0, {rq, " ctrl code"}, c0, e0);
    chk(cb == eb, {rq, " other code"}, cb, eb);
    chk(n0 == 1 && nb == 1 && ok_at == 1, "R2 single valid at fixed cycle", n0 + nb, 2);
    chk(d0 == (e0 == ACK ? DL : 0), "R5 ctrl data cycles", d0, e0 == ACK ? DL : 0);
    chk(db == (eb == ACK ? DL : 0), "R5 other data cycles", db, eb == ACK ? DL : 0);
  endtask

  task automatic pulse_clr();
    stall_clr = 1; @(posedge clk); @(negedge clk); stall_clr = 0;
  endtask

  task automatic t_reset();
    chk(v0 == 0 && de0 == 0 && vb == 0 && deb == 0, "R1 outputs idle", {v0, de0}, 0);
    buf_nak = 0;
    txn(99, ACK, ACK, "R1");
  endtask

  task automatic t_sweep_ready();
    buf_nak = 0;
    for (int k = -1; k <= LASTC; k++) begin
      pulse_clr();
      txn(k, (k <= GAP) ? STL : ACK, (k <= 0) ? STL : ACK, (k <= GAP) ? "R3" : "R6");
      txn(99, STL, (k <= 0) ? STL : ACK, "R6 R9 next token");
    end
    pulse_clr();
  endtask

  task automatic t_sweep_nak();
    buf_nak = 1;
    for (int k = -1; k <= LASTC; k++) begin
      pulse_clr();
      txn(k, (k <= GAP) ? STL : NAK, (k <= 0) ? STL : NAK, "R4");
    end
    pulse_clr();
    txn(99, NAK, NAK, "R4 no stall");
    buf_nak = 0;
  endtask

  task automatic t_auto();
    auto_mode = 1;
    txn(2, ACK, ACK, "R8 during txn");
    txn(-1, ACK, ACK, "R8 idle");
    auto_mode = 0;
    txn(99, ACK, ACK, "R8 follow-up");
  endtask

  task automatic t_setup();
    stall_set = 1; @(posedge clk); @(negedge clk); stall_set = 0;
    setup_tok = 1; @(posedge clk); @(negedge clk); setup_tok = 0;
    txn(99, ACK, ACK, "R7 setup clears");
    stall_set = 1; stall_clr = 1; @(posedge clk); @(negedge clk);
    stall_set = 0; stall_clr = 0;
    txn(99, ACK, ACK, "R7 clear wins");
    stall_set = 1; @(posedge clk); @(negedge clk); stall_set = 0;
    txn(99, STL, STL, "R7 sticky 1");
    txn(99, STL, STL, "R7 sticky 2");
    pulse_clr();
    txn(99, ACK, ACK, "R7 after clear");
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sweep_ready();
    t_sweep_nak();
    t_auto();
    t_setup();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      vectors++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule